// File: doc/BRIEF.md
# Modulo Position Counter with Buffered Limits

This block keeps the position of a motor shaft or other moving axis. A quadrature or pulse decoder in front of it produces one-cycle up and down strobes. The block turns these strobes into a 32-bit position that wraps inside a window. The low end of the window is an initial value and the high end is a modulus value. Each wrap raises a sticky event flag and can step a 16-bit revolution counter. An index pulse can step the revolution counter instead. Four compare values watch the position and raise their own sticky flags when the position lands on them.

Software writes the window limits and the compare values into shadow registers. These writes have no effect on counting until software sets a self-clearing load-okay bit. The shadow contents then move into the active registers. The move happens either on the next clock or at the next roll-over or roll-under, so the limits never change in the middle of a revolution. A preload strobe puts the active initial value into the position.

Top module: `pos_wrap_counter`

## Requirements
- R1: When the up strobe is high alone and the position equals the active modulus, the position becomes the active initial value and flag bit 0 (roll-over) sets. If the active modulus is 0, the same happens only at 0xFFFFFFFF, and the position becomes 0.
- R2: When the down strobe is high alone and the position equals the active initial value, the position becomes the active modulus and flag bit 1 (roll-under) sets. If the active modulus is 0, the same happens only at 0, and the position becomes 0xFFFFFFFF.
- R3: Away from a wrap, the up strobe alone adds 1 to the position and the down strobe alone subtracts 1. If both strobes are high, or neither is, the position holds. The new position appears on the clock edge that samples the strobe.
- R4: A write to address 0 (initial), address 1 (modulus) or address 4+i (compare i) changes only the shadow copy. Counting, preload and compare keep using the active copies until a transfer.
- R5: Writing address 2 with bit 0 set raises the load-okay output. Bit 1 of the same write stores the load mode and bit 2 stores the revolution source. With load mode 0, the transfer happens on the next edge, and load-okay reads 0 after that edge.
- R6: With load mode 1, load-okay stays set and no transfer happens until a roll-over or roll-under. The transfer happens on that same edge, and load-okay then clears.
- R7: The preload strobe loads the active initial value into the position. It takes priority over both count strobes, and a preload raises no wrap flag.
- R8: Flag bit 2+i sets one edge after the position first shows a value equal to active compare i. All compare values reset to 0xFFFFFFFF.
- R9: With revolution source 1, a roll-over adds 1 to the revolution counter, a roll-under subtracts 1, and the index pulse is ignored.
- R10: With revolution source 0 (the reset value), each index pulse steps the revolution counter. It steps up if the current strobe counts up, or if no strobe is active and the last count was up. Otherwise it steps down. Wraps do not change the counter in this mode. After reset, the last direction counts as up.
- R11: Flags are sticky. Writing address 3 clears each flag whose data bit is 1. If the flag's event occurs on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntUp | input | 1 | Count-up strobe |
| cntDn | input | 1 | Count-down strobe |
| idxPulse | input | 1 | Index pulse strobe |
| preload | input | 1 | Load the active initial value into the position |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W (3) | Register write address |
| wrData | input | POS_W (32) | Register write data |
| position | output | POS_W (32) | Current position |
| revCount | output | REV_W (16) | Revolution counter |
| ldOk | output | 1 | Load-okay bit, cleared by hardware after a transfer |
| flags | output | FLAG_W (6) | Sticky flags: bit 0 roll-over, bit 1 roll-under, bits 2..5 compare 0..3 |

## Verification
Position, revolution count, load-okay and the wrap flags all change on the edge that samples the strobe or the write. The bench therefore drives each stimulus on a falling edge and reads these results on the next falling edge. A compare flag takes one more edge, because it is built from the registered position. The compare checks idle one cycle before sampling, and they also confirm that the flag is still clear on the sample just before that. Buffered transfers are checked across several strobes: load-okay must stay high until the edge of the wrap, and the new compare value may take effect only after that edge.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // Control to datapath strobes
  typedef struct packed {
    logic xfer;       // shadow -> active copy this edge
    logic revOnWrap;  // revolution source select
    logic initWr;     // shadow initial write
    logic modWr;      // shadow modulus write
  } strobes_t;

  // Datapath events toward the control flags
  typedef struct packed {
    logic rollOver;
    logic rollUnder;
  } events_t;
endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int N_CMP  = 4,
  parameter int ADDR_W = 3,
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [POS_W-1:0]  wrData,
  input  events_t           evt,
  input  logic [N_CMP-1:0]  cmpHit,
  output strobes_t          strb,
  output logic [N_CMP-1:0]  cmpWr,
  output logic              ldOk,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3);
  localparam int CMP_BASE = 4;

  logic ldOkQ, ldModeQ, revOnWrapQ;
  logic [FLAG_W-1:0] flagsQ;
  logic ctrlWr, clrWr;
  logic [FLAG_W-1:0] evtVec, clrMask;

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);
  assign clrWr  = wrEn && (wrAddr == A_CLR);

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmpWr
      assign cmpWr[i] = wrEn && (wrAddr == ADDR_W'(CMP_BASE + i));
    end
  endgenerate

  always_comb begin
    strb.initWr    = wrEn && (wrAddr == A_INIT);
    strb.modWr     = wrEn && (wrAddr == A_MOD);
    strb.revOnWrap = revOnWrapQ;
    strb.xfer      = ldOkQ && (!ldModeQ || evt.rollOver || evt.rollUnder);
  end

  assign evtVec  = {cmpHit, evt.rollUnder, evt.rollOver};
  assign clrMask = clrWr ? wrData[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldOkQ      <= 1'b0;
      ldModeQ    <= 1'b0;
      revOnWrapQ <= 1'b0;
      flagsQ     <= '0;
    end else begin
      ldOkQ  <= (ldOkQ && !strb.xfer) || (ctrlWr && wrData[0]);
      flagsQ <= (flagsQ & ~clrMask) | evtVec;
      if (ctrlWr) begin
        ldModeQ    <= wrData[1];
        revOnWrapQ <= wrData[2];
      end
    end
  end

  assign ldOk  = ldOkQ;
  assign flags = flagsQ;
endmodule

// File: rtl/pwc_path.sv
module pwc_path
  import pwc_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int REV_W = 16,
  parameter int N_CMP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntUp,
  input  logic             cntDn,
  input  logic             preload,
  input  logic             idxPulse,
  input  logic [POS_W-1:0] wrData,
  input  strobes_t         strb,
  input  logic [N_CMP-1:0] cmpWr,
  output logic [POS_W-1:0] position,
  output logic [REV_W-1:0] revCount,
  output events_t          evt,
  output logic [N_CMP-1:0] cmpHit
);
  logic [POS_W-1:0] initSh, modSh, initAct, modAct, posQ, posNext;
  logic [POS_W-1:0] topVal, botVal;
  logic [REV_W-1:0] revQ, revNext;
  logic lastUpQ, stepUp, stepDn, dirUp, modZero;

  assign stepUp  = cntUp && !cntDn;
  assign stepDn  = cntDn && !cntUp;
  assign modZero = (modAct == '0);
  assign topVal  = modZero ? '1 : modAct;
  assign botVal  = modZero ? '0 : initAct;
  assign dirUp   = stepUp || (!stepDn && lastUpQ);

  always_comb begin
    evt.rollOver  = !preload && stepUp && (posQ == topVal);
    evt.rollUnder = !preload && stepDn && (posQ == botVal);
    if (preload)            posNext = initAct;
    else if (evt.rollOver)  posNext = botVal;
    else if (evt.rollUnder) posNext = topVal;
    else if (stepUp)        posNext = posQ + POS_W'(1);
    else if (stepDn)        posNext = posQ - POS_W'(1);
    else                    posNext = posQ;

    revNext = revQ;
    if (strb.revOnWrap) begin
      if (evt.rollOver)       revNext = revQ + REV_W'(1);
      else if (evt.rollUnder) revNext = revQ - REV_W'(1);
    end else if (idxPulse) begin
      revNext = dirUp ? revQ + REV_W'(1) : revQ - REV_W'(1);
    end
  end

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      logic [POS_W-1:0] cmpSh, cmpAct;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpSh  <= '1;
          cmpAct <= '1;
        end else begin
          if (cmpWr[i])  cmpSh  <= wrData;
          if (strb.xfer) cmpAct <= cmpSh;
        end
      end
      assign cmpHit[i] = (posQ == cmpAct);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initSh  <= '0;
      modSh   <= '0;
      initAct <= '0;
      modAct  <= '0;
      posQ    <= '0;
      revQ    <= '0;
      lastUpQ <= 1'b1;
    end else begin
      if (strb.initWr) initSh <= wrData;
      if (strb.modWr)  modSh  <= wrData;
      if (strb.xfer) begin
        initAct <= initSh;
        modAct  <= modSh;
      end
      posQ <= posNext;
      revQ <= revNext;
      if (stepUp || stepDn) lastUpQ <= stepUp;
    end
  end

  assign position = posQ;
  assign revCount = revQ;
endmodule

// File: rtl/pos_wrap_counter.sv
module pos_wrap_counter
  import pwc_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int REV_W  = 16,
  parameter int N_CMP  = 4,
  parameter int ADDR_W = $clog2(N_CMP + 4),
  parameter int FLAG_W = N_CMP + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntUp,
  input  logic              cntDn,
  input  logic              idxPulse,
  input  logic              preload,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [POS_W-1:0]  wrData,
  output logic [POS_W-1:0]  position,
  output logic [REV_W-1:0]  revCount,
  output logic              ldOk,
  output logic [FLAG_W-1:0] flags
);
  strobes_t          strb;
  events_t           evt;
  logic [N_CMP-1:0]  cmpHit, cmpWr;

  pwc_ctrl #(.POS_W(POS_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evt(evt), .cmpHit(cmpHit), .strb(strb), .cmpWr(cmpWr),
    .ldOk(ldOk), .flags(flags)
  );

  pwc_path #(.POS_W(POS_W), .REV_W(REV_W), .N_CMP(N_CMP)) u_path (
    .clk(clk), .rstN(rstN), .cntUp(cntUp), .cntDn(cntDn), .preload(preload),
    .idxPulse(idxPulse), .wrData(wrData), .strb(strb), .cmpWr(cmpWr),
    .position(position), .revCount(revCount), .evt(evt), .cmpHit(cmpHit)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int POS_W  = 32,
  parameter int ADDR_W = 3,
  parameter int FLAG_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cntUp,
  input logic              cntDn,
  input logic              preload,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [POS_W-1:0]  wrData,
  input logic [POS_W-1:0]  position,
  input logic              ldOk,
  input logic [FLAG_W-1:0] flags,
  input logic              rollOver,
  input logic              rollUnder,
  input logic              xfer
);
  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntUp && !cntDn && !preload && !rollOver) |=> position == $past(position) + POS_W'(1));
  // R3
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!preload && (cntUp == cntDn)) |=> $stable(position));
  // R1
  roll_over_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollOver |=> flags[0]);
  // R2
  roll_under_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollUnder |=> flags[1]);
  // R5
  ldok_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !(wrEn && wrAddr == ADDR_W'(2) && wrData[0])) |=> !ldOk);
  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(3) && wrData[0] && !rollOver) |=> !flags[0]);
endmodule

bind pos_wrap_counter pwc_checker #(.POS_W(POS_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) i_chk (
  .clk(clk), .rstN(rstN), .cntUp(cntUp), .cntDn(cntDn), .preload(preload),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .position(position),
  .ldOk(ldOk), .flags(flags), .rollOver(evt.rollOver), .rollUnder(evt.rollUnder),
  .xfer(strb.xfer)
);

// File: tb/test_pos_wrap_counter.sv
module test_pos_wrap_counter;
  logic clk = 1'b0, rstN = 1'b0;
  logic cntUp = 0, cntDn = 0, idxPulse = 0, preload = 0, wrEn = 0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] position;
  logic [15:0] revCount;
  logic ldOk;
  logic [5:0] flags;
  int tests = 0, failed = 0;

  always #4 clk = ~clk;

  pos_wrap_counter i_pos_wrap_counter (
    .clk(clk), .rstN(rstN), .cntUp(cntUp), .cntDn(cntDn), .idxPulse(idxPulse),
    .preload(preload), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .position(position), .revCount(revCount), .ldOk(ldOk), .flags(flags)
  );

  // {up, dn, preload, expected position, expected revolutions}
  localparam logic [50:0] VEC [14] = '{
    {3'b001, 32'd10, 16'h0000}, {3'b100, 32'd11, 16'h0000},
    {3'b100, 32'd12, 16'h0000}, {3'b100, 32'd13, 16'h0000},
    {3'b100, 32'd10, 16'h0001}, {3'b000, 32'd10, 16'h0001},
    {3'b010, 32'd13, 16'h0000}, {3'b010, 32'd12, 16'h0000},
    {3'b110, 32'd12, 16'h0000}, {3'b010, 32'd11, 16'h0000},
    {3'b010, 32'd10, 16'h0000}, {3'b010, 32'd13, 16'hFFFF},
    {3'b101, 32'd10, 16'hFFFF}, {3'b100, 32'd11, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic up, input logic dn, input logic pre, input logic idx);
    cntUp = up; cntDn = dn; preload = pre; idxPulse = idx;
    @(negedge clk);
    cntUp = 0; cntDn = 0; preload = 0; idxPulse = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R8: compares at all-ones, so no hit at 0)
    chk("R8 reset position", position, 0);
    chk("R10 reset revolutions", {16'h0, revCount}, 0);
    chk("R11 reset flags", {26'h0, flags}, 0);
    chk("R5 reset ldOk", {31'h0, ldOk}, 0);

    // R3 plain counting, R4 shadow writes stay inactive
    cyc(1, 0, 0, 0); chk("R3 up", position, 1);
    cyc(1, 0, 0, 0); chk("R3 up", position, 2);
    wr(0, 10); wr(1, 13);
    cyc(0, 0, 1, 0); chk("R4 preload uses old initial", position, 0);

    // R5 immediate transfer, revolution source = wraps
    wr(2, 32'h5); chk("R5 ldOk set", {31'h0, ldOk}, 1);
    cyc(0, 0, 0, 0); chk("R5 ldOk self-clear", {31'h0, ldOk}, 0);

    // table: R1 R2 R3 R7 R9
    for (int k = 0; k < 14; k++) begin
      cyc(VEC[k][50], VEC[k][49], VEC[k][48], 1'b0);
      chk("R1/R2/R3/R7 table position", position, VEC[k][47:16]);
      chk("R9 table revolutions", {16'h0, revCount}, {16'h0, VEC[k][15:0]});
    end
    chk("R1/R2 wrap flags", {26'h0, flags}, 32'h3);
    wr(3, 32'h3f); chk("R11 w1c clear", {26'h0, flags}, 0);

    // R6 buffered transfer at next wrap, R8 compare
    wr(4, 11);
    wr(2, 32'h7); chk("R6 ldOk set", {31'h0, ldOk}, 1);
    cyc(1, 0, 0, 0); chk("R6 ldOk held", {31'h0, ldOk}, 1);
    chk("R4 compare not active", {31'h0, flags[2]}, 0);
    cyc(1, 0, 0, 0); chk("R6 ldOk held", {31'h0, ldOk}, 1);
    cyc(1, 0, 0, 0); chk("R6 ldOk cleared at wrap", {31'h0, ldOk}, 0);
    chk("R9 rev after wrap", {16'h0, revCount}, 0);
    cyc(1, 0, 0, 0); chk("R8 position at compare", position, 11);
    chk("R8 flag one edge later", {31'h0, flags[2]}, 0);
    cyc(0, 0, 0, 0); chk("R8 compare flag", {31'h0, flags[2]}, 1);
    wr(3, 32'h4); chk("R11 same-cycle event keeps flag", {31'h0, flags[2]}, 1);
    cyc(1, 0, 0, 0);
    wr(3, 32'h4); chk("R11 clear after leaving", {31'h0, flags[2]}, 0);

    // R10 index mode
    wr(2, 32'h0);
    cyc(0, 0, 0, 1); chk("R10 index after up", {16'h0, revCount}, 1);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1); chk("R10 index after down", {16'h0, revCount}, 0);
    cyc(1, 0, 0, 1); chk("R10 index with up", {16'h0, revCount}, 1);
    chk("R3 up with index", position, 12);

    // R1/R2 modulus zero
    wr(3, 32'h3f);
    wr(0, 0); wr(1, 0); wr(2, 32'h1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0); chk("R7 preload", position, 0);
    cyc(0, 1, 0, 0); chk("R2 mod0 down wrap", position, 32'hFFFFFFFF);
    chk("R2 roll-under flag", {31'h0, flags[1]}, 1);
    chk("R10 wrap ignored", {16'h0, revCount}, 1);
    cyc(1, 0, 0, 0); chk("R1 mod0 up wrap", position, 0);
    chk("R1 roll-over flag", {31'h0, flags[0]}, 1);
    chk("R10 wrap ignored", {16'h0, revCount}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule